// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

The scanner turns a latched multi-digit BCD conversion result into a time-multiplexed display bus. When an end-of-conversion pulse arrives it captures the result and the overrange flag. It then sweeps a one-hot set of digit-select lines from the most significant digit down to the least significant one. The BCD nibble of the selected digit is driven beside the select lines. The first slot of every sweep is one conversion clock longer than the others. An active-low strobe marks the middle of each slot, so a processor, UART or external latch can capture the digits. The five strobes come only once per new result. Later sweeps of the same result refresh the display without strobes.

The block runs on a clock at twice the conversion rate. A clock enable, `clk_en`, marks every other edge as a conversion-clock edge. Counters advance only on those edges. The strobe is one fast cycle wide, which is half a conversion clock, and the whole block stays synchronous to one clock. When the captured result is overrange, the data nibble reads zero. The sweep is cut off right after the last strobe and stays dark until the analog side signals the start of its next reference-integrate phase. A pulse on `ref_int_start` then starts one more sweep without strobes, which makes the display blink.

Top module: `bcd_digit_scanner`

## Requirements
- R1: While reset is asserted and afterwards until the first end-of-conversion pulse, `dig_sel` is all zero, `strobe_n` is high and `bcd` is zero.
- R2: An `eoc` pulse seen on a conversion edge (`clk_en` high) starts a sweep. `dig_sel[4]` (most significant digit) is high for 201 conversion clocks, then `dig_sel[3]`, `dig_sel[2]`, `dig_sel[1]`, `dig_sel[0]` are each high for 200 conversion clocks. At most one select is high at a time, and a non-overrange sweep wraps back to `dig_sel[4]` indefinitely.
- R3: `bcd` carries the nibble of the selected digit and changes on the same edge as `dig_sel`. Digit k occupies `result_digits[4k+3:4k]`, with bit 4k as the least significant bit. `bcd` is zero when no select is high.
- R4: `strobe_n` is low for exactly one fast clock, the second half of a conversion clock. In the first slot this is when 101 conversion clocks have elapsed since the `eoc` edge. In each later slot it is when 100 conversion clocks have elapsed since that select rose.
- R5: Each `eoc` pulse yields exactly five strobe pulses. Later sweeps of the same result produce no strobes.
- R6: When `over_range` is high with `eoc`, `bcd` stays zero and all selects drop at the conversion edge ending the least significant digit's strobe. They stay low until a `ref_int_start` pulse, which starts a new strobe-free sweep that blanks again at the same point.
- R7: An `eoc` pulse during a sweep restarts the sweep at the most significant digit with the newly captured data and five fresh strobes.
- R8: `ref_int_start` has no effect unless the captured result is overrange and the display is blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the conversion rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | High on every other edge; marks conversion-clock edges |
| result_digits | input | 20 | Latched BCD result, digit k in bits 4k+3..4k, digit 4 most significant |
| over_range | input | 1 | Overrange flag of the result, captured with `eoc` |
| eoc | input | 1 | End-of-conversion pulse, sampled on conversion edges |
| ref_int_start | input | 1 | Start of reference-integrate phase, sampled on conversion edges |
| dig_sel | output | 5 | One-hot active-high digit selects, bit 4 most significant |
| bcd | output | 4 | BCD nibble of the selected digit, positive-true |
| strobe_n | output | 1 | Active-low half-conversion-clock capture strobe |

## Verification
The assertions assume that `clk_en` alternates strictly, high on every second edge. The check that a strobe falls only in the second half of a conversion clock depends on that. They also assume that `eoc` and `ref_int_start` are one-edge pulses aligned to a `clk_en` edge. The bench generates `clk_en` by toggling it on every falling edge. It raises each pulse only after confirming that the next rising edge carries the enable, and drops it one nanosecond after that edge. This keeps every stimulus inside those assumptions.

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner #(
  parameter int NDIG      = 5,
  parameter int DIG_W     = 4,
  parameter int SLOT_CLKS = 200,
  parameter int STRB_OFS  = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clk_en,
  input  logic [NDIG*DIG_W-1:0] result_digits,
  input  logic                  over_range,
  input  logic                  eoc,
  input  logic                  ref_int_start,
  output logic [NDIG-1:0]       dig_sel,
  output logic [DIG_W-1:0]      bcd,
  output logic                  strobe_n
);
  localparam int CW = $clog2(SLOT_CLKS + 1);
  localparam int SW = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam logic [SW-1:0] MSD = SW'(NDIG - 1);

  logic                  active, armed, ovr_q;
  logic [SW-1:0]         slot;
  logic [CW-1:0]         cnt;
  logic [NDIG*DIG_W-1:0] data_q;

  logic          is_msd, at_end, at_strb, blank_now;
  logic [CW-1:0] slot_end, strb_pt;

  assign is_msd    = (slot == MSD);
  assign slot_end  = is_msd ? CW'(SLOT_CLKS) : CW'(SLOT_CLKS - 1);
  assign strb_pt   = is_msd ? CW'(STRB_OFS + 1) : CW'(STRB_OFS);
  assign at_end    = (cnt == slot_end);
  assign at_strb   = (cnt == strb_pt);
  assign blank_now = ovr_q && (slot == '0) && at_strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      armed  <= 1'b0;
      ovr_q  <= 1'b0;
      slot   <= '0;
      cnt    <= '0;
      data_q <= '0;
    end else if (clk_en) begin
      if (eoc) begin
        data_q <= result_digits;
        ovr_q  <= over_range;
        active <= 1'b1;
        armed  <= 1'b1;
        slot   <= MSD;
        cnt    <= '0;
      end else if (active) begin
        if (blank_now) begin
          active <= 1'b0;
          armed  <= 1'b0;
          cnt    <= '0;
        end else if (at_end) begin
          cnt <= '0;
          if (slot == '0) begin
            slot  <= MSD;
            armed <= 1'b0;
          end else begin
            slot <= slot - 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (ref_int_start && ovr_q) begin
        active <= 1'b1;
        slot   <= MSD;
        cnt    <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_n <= 1'b1;
    else        strobe_n <= !(active && armed && !clk_en && at_strb);
  end

  for (genvar k = 0; k < NDIG; k++) begin : g_sel
    assign dig_sel[k] = active && (slot == SW'(k));
  end

  always_comb begin
    bcd = '0;
    if (active && !ovr_q)
      for (int k = 0; k < NDIG; k++)
        if (slot == SW'(k)) bcd = data_q[k*DIG_W +: DIG_W];
  end
endmodule

// File: rtl/scanner_checks.sv
module scanner_checks #(
  parameter int NDIG  = 5,
  parameter int DIG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic [NDIG-1:0]  dig_sel,
  input logic [DIG_W-1:0] bcd,
  input logic             strobe_n,
  input logic             ovr_q
);
  assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_sel));

  assert_sel_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(dig_sel));

  assert_idle_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_sel == '0) |-> (bcd == '0));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |=> strobe_n);

  assert_strobe_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> (clk_en && dig_sel != '0));

  assert_ovr_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> (bcd == '0));
endmodule

bind bcd_digit_scanner scanner_checks #(.NDIG(NDIG), .DIG_W(DIG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .dig_sel(dig_sel),
  .bcd(bcd), .strobe_n(strobe_n), .ovr_q(ovr_q)
);

// File: tb/bcd_digit_scanner_test.sv
module bcd_digit_scanner_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  localparam int VOFF [NV] = '{0, 202, 203, 204, 401, 402, 603, 604, 801,
                               802, 1003, 1202, 1403, 1602, 1803, 2001, 2002, 2205};
  localparam logic [4:0] VSEL [NV] = '{5'b10000, 5'b10000, 5'b10000, 5'b10000,
    5'b10000, 5'b01000, 5'b01000, 5'b01000, 5'b01000, 5'b00100, 5'b00100,
    5'b00010, 5'b00010, 5'b00001, 5'b00001, 5'b00001, 5'b10000, 5'b10000};
  localparam logic VSTB [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0;
  logic [19:0] result_digits = '0;
  logic over_range = 1'b0, eoc = 1'b0, ref_int_start = 1'b0;
  logic [4:0] dig_sel;
  logic [3:0] bcd;
  logic strobe_n;

  int cyc = 0, stb_cnt = 0, n_checks = 0, n_err = 0;
  int e0, e1, e2, e3, r0;
  logic [19:0] cur_data;

  bcd_digit_scanner uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .result_digits(result_digits),
    .over_range(over_range), .eoc(eoc), .ref_int_start(ref_int_start),
    .dig_sel(dig_sel), .bcd(bcd), .strobe_n(strobe_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) clk_en <= ~clk_en;
  always @(negedge clk) if (!strobe_n) stb_cnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_bcd(logic [4:0] sel, logic [19:0] d, logic ovr);
    exp_bcd = 4'h0;
    if (!ovr)
      for (int k = 0; k < 5; k++) if (sel[k]) exp_bcd = d[4*k +: 4];
  endfunction

  task automatic goto(int t);
    while (cyc < t) begin @(posedge clk); #1; end
    #1;
  endtask

  task automatic align_en;
    @(negedge clk); #1;
    if (!clk_en) begin @(negedge clk); #1; end
  endtask

  task automatic pulse_eoc(logic [19:0] d, logic ovr, output int at);
    align_en();
    result_digits = d; over_range = ovr; eoc = 1'b1;
    @(posedge clk); #1;
    eoc = 1'b0; at = cyc; stb_cnt = 0; cur_data = d;
  endtask

  task automatic pulse_ref(output int at);
    align_en();
    ref_int_start = 1'b1;
    @(posedge clk); #1;
    ref_int_start = 1'b0; at = cyc; stb_cnt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset sel", dig_sel, 5'b0);
    chk("R1 reset strobe", strobe_n, 1'b1);
    chk("R1 reset bcd", bcd, 4'h0);
    rst_n = 1'b1;
    pulse_ref(r0);
    goto(r0 + 10);
    chk("R8 ref idle sel", dig_sel, 5'b0);
    chk("R1 idle strobe", strobe_n, 1'b1);

    pulse_eoc(20'h19735, 1'b0, e0);
    for (int i = 0; i < NV; i++) begin
      goto(e0 + VOFF[i]);
      chk("R2 sel vector", dig_sel, VSEL[i]);
      chk("R4 strobe vector", strobe_n, VSTB[i]);
      chk("R3 bcd vector", bcd, exp_bcd(VSEL[i], cur_data, 1'b0));
    end
    chk("R5 strobes first sweep", stb_cnt, 5);
    stb_cnt = 0;
    goto(e0 + 2300);
    pulse_ref(r0);
    goto(e0 + 2403);
    chk("R8 ref ignored sel", dig_sel, 5'b10000);
    goto(e0 + 2404);
    chk("R8 ref ignored next slot", dig_sel, 5'b01000);
    goto(e0 + 4003);
    chk("R5 no strobe on repeat", stb_cnt, 0);
    goto(e0 + 4004);
    chk("R2 wrap again", dig_sel, 5'b10000);

    goto(e0 + 4700);
    pulse_eoc(20'h14821, 1'b0, e1);
    chk("R7 restart sel", dig_sel, 5'b10000);
    chk("R7 restart bcd", bcd, 4'h1);
    goto(e1 + 402);
    chk("R7 new data D4", bcd, 4'h4);
    goto(e1 + 603);
    chk("R7 fresh strobe", strobe_n, 1'b0);
    goto(e1 + 2001);
    chk("R7 five strobes", stb_cnt, 5);

    pulse_eoc(20'h12345, 1'b1, e2);
    chk("R6 ovr sel", dig_sel, 5'b10000);
    chk("R6 ovr bcd zero", bcd, 4'h0);
    goto(e2 + 203);
    chk("R6 ovr strobe", strobe_n, 1'b0);
    goto(e2 + 1803);
    chk("R6 last digit at strobe", dig_sel, 5'b00001);
    chk("R6 last strobe", strobe_n, 1'b0);
    goto(e2 + 1804);
    chk("R6 blanked", dig_sel, 5'b0);
    chk("R5 five strobes ovr", stb_cnt, 5);
    goto(e2 + 3000);
    chk("R6 still blanked", dig_sel, 5'b0);
    chk("R6 blank bcd", bcd, 4'h0);
    pulse_ref(r0);
    chk("R6 rescan sel", dig_sel, 5'b10000);
    chk("R6 rescan bcd", bcd, 4'h0);
    goto(r0 + 203);
    chk("R6 rescan no strobe", strobe_n, 1'b1);
    goto(r0 + 1803);
    chk("R6 rescan last digit", dig_sel, 5'b00001);
    goto(r0 + 1804);
    chk("R6 reblank", dig_sel, 5'b0);
    chk("R6 rescan strobes", stb_cnt, 0);

    pulse_eoc(20'h05678, 1'b0, e3);
    chk("R3 zero msd", bcd, 4'h0);
    goto(e3 + 1602);
    chk("R3 lsd nibble", bcd, 4'h8);
    goto(e3 + 1804);
    chk("R6 no blank when clear", dig_sel, 5'b00001);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule